// File: doc/BRIEF.md
# Vertical Sync Mask, Fill and Field Detect

This block turns a raw vertical sync into a clean frame pulse and an odd/even field flag for a downstream data slicer. A half-line counter advances once for every tick on `half_tick`, an enable that arrives at twice the horizontal line rate. The raw vertical sync is taken from one of two places: the sync separated from the composite signal, or a dedicated vertical sync pin. `src_sel` chooses between them.

Both the masking and the substitute-pulse logic compare the half-line count with a register value. A rising edge of the selected sync counts only once the count has reached `mask_start`. Any earlier edge is treated as noise. If no sync has arrived by the time the count reaches `fill_pos`, the block inserts a substitute frame pulse of its own. Every frame pulse, real or substituted, sets the counter back to zero. An accepted pulse sets the field from the parity of the half-line count at which it arrived. `fill_flag` records whether the most recent frame pulse was real or substituted.

Top module: `vsync_field_gen`

## Requirements
- R1: While `rst` is high at a clock edge, `frame_pulse`, `field_odd` and `fill_flag` go to 0 and the half-line count goes to 0.
- R2: With `src_sel` = 0 the raw sync is `vs_comp`, and with `src_sel` = 1 it is `vs_pin`. Edges on the unselected input have no effect on any output.
- R3: A rising edge of the selected sync, seen at a clock edge where the count is at least `mask_start`, is accepted. `frame_pulse` is 1 for exactly the following clock cycle and `fill_flag` becomes 0.
- R4: A rising edge seen while the count is below `mask_start` is ignored, and no frame pulse follows.
- R5: The count rises by one at each clock edge where `half_tick` is 1. It holds its value at every other edge.
- R6: At a clock edge where `half_tick` is 1, the count is at least `fill_pos` and no edge is accepted, a substitute pulse is made. `frame_pulse` is 1 for the following cycle and `fill_flag` becomes 1.
- R7: Any frame pulse, accepted or substituted, resets the count to 0 at the same edge, so the next window is measured from that pulse.
- R8: On an accepted pulse, `field_odd` takes bit 0 of the count at the accepting edge, with 1 meaning odd. On a substituted pulse, `field_odd` inverts.
- R9: When an accepted edge and a due substitute fall on the same clock edge, the accepted edge wins and `fill_flag` becomes 0. Between pulses, `field_odd` and `fill_flag` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| half_tick | input | 1 | One-cycle enable at twice the line rate |
| src_sel | input | 1 | 0: composite-derived sync, 1: sync pin |
| vs_comp | input | 1 | Raw vertical sync from composite separation |
| vs_pin | input | 1 | Raw vertical sync from the dedicated pin |
| mask_start | input | CNT_W | First half-line count at which sync is accepted |
| fill_pos | input | CNT_W | Half-line count at which a substitute pulse is made |
| frame_pulse | output | 1 | One-cycle clean frame pulse |
| field_odd | output | 1 | Current field, 1 = odd |
| fill_flag | output | 1 | 1 if the last frame pulse was substituted |

## Verification
The bench builds the block with `CNT_W` = 6, so the count can reach any register setting within a few dozen ticks. That keeps mask windows, fill positions and same-edge collisions of a real edge with a due substitute cheap to reach. With this width the bench runs long random stretches of ticks, noise edges and source switching against its integer model. The fill position is also set to the top count value, 63.

// File: rtl/vsm_pkg.sv
package vsm_pkg;

    localparam int unsigned CMP_W = 16;

    typedef enum logic {
        SRC_COMPOSITE = 1'b0,
        SRC_PIN       = 1'b1
    } vs_src_e;

    typedef struct packed {
        logic accept;
        logic fill;
    } frame_ev_t;

    function automatic logic at_or_past(input logic [CMP_W-1:0] cnt,
                                        input logic [CMP_W-1:0] lim);
        return cnt >= lim;
    endfunction

endpackage

// File: rtl/vsm_src_edge.sv
module vsm_src_edge
    import vsm_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic src_sel,
    input  logic vs_comp,
    input  logic vs_pin,
    output logic rise
);
    vs_src_e src;
    logic    vs_now;
    logic    vs_prev;

    assign src    = vs_src_e'(src_sel);
    assign vs_now = (src == SRC_PIN) ? vs_pin : vs_comp;
    assign rise   = vs_now & ~vs_prev;

    always_ff @(posedge clk) begin
        if (rst) vs_prev <= 1'b0;
        else     vs_prev <= vs_now;
    end

    // R2: a rising edge can only come from the selected input
    a_r2_edge_from_selected: assert property (@(posedge clk) disable iff (rst)
        rise |-> (src_sel ? vs_pin : vs_comp));

endmodule

// File: rtl/vsm_halfline_cnt.sv
module vsm_halfline_cnt #(
    parameter int unsigned CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             clear,
    output logic [CNT_W-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (rst || clear) cnt <= '0;
        else if (tick)    cnt <= cnt + 1'b1;
    end

    // R5: without a tick or a clear, the count holds
    a_r5_hold: assert property (@(posedge clk) disable iff (rst)
        (!tick && !clear) |=> $stable(cnt));

    // R7: a clear leaves the count at zero
    a_r7_clear: assert property (@(posedge clk) disable iff (rst)
        clear |=> (cnt == '0));

endmodule

// File: rtl/vsm_frame_out.sv
module vsm_frame_out
    import vsm_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  frame_ev_t ev,
    input  logic      cnt_lsb,
    output logic      frame_pulse,
    output logic      field_odd,
    output logic      fill_flag
);
    always_ff @(posedge clk) begin
        if (rst) begin
            frame_pulse <= 1'b0;
            field_odd   <= 1'b0;
            fill_flag   <= 1'b0;
        end else begin
            frame_pulse <= ev.accept | ev.fill;
            if (ev.accept) begin
                field_odd <= cnt_lsb;
                fill_flag <= 1'b0;
            end else if (ev.fill) begin
                field_odd <= ~field_odd;
                fill_flag <= 1'b1;
            end
        end
    end

    // R8: a substituted pulse inverts the field
    a_r8_fill_toggles: assert property (@(posedge clk) disable iff (rst)
        (ev.fill && !ev.accept) |=> (field_odd != $past(field_odd)) && fill_flag);

    // R9: between pulses the field and the flag hold
    a_r9_hold: assert property (@(posedge clk) disable iff (rst)
        (!ev.accept && !ev.fill) |=> ($stable(field_odd) && $stable(fill_flag) && !frame_pulse));

endmodule

// File: rtl/vsync_field_gen.sv
module vsync_field_gen
    import vsm_pkg::*;
#(
    parameter int unsigned CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             half_tick,
    input  logic             src_sel,
    input  logic             vs_comp,
    input  logic             vs_pin,
    input  logic [CNT_W-1:0] mask_start,
    input  logic [CNT_W-1:0] fill_pos,
    output logic             frame_pulse,
    output logic             field_odd,
    output logic             fill_flag
);
    localparam int unsigned PAD_W = CMP_W - CNT_W;

    logic             rise;
    logic [CNT_W-1:0] cnt;
    frame_ev_t        ev;

    vsm_src_edge u_edge (
        .clk     (clk),
        .rst     (rst),
        .src_sel (src_sel),
        .vs_comp (vs_comp),
        .vs_pin  (vs_pin),
        .rise    (rise)
    );

    always_comb begin
        ev.accept = rise && at_or_past({{PAD_W{1'b0}}, cnt}, {{PAD_W{1'b0}}, mask_start});
        ev.fill   = !ev.accept && half_tick &&
                    at_or_past({{PAD_W{1'b0}}, cnt}, {{PAD_W{1'b0}}, fill_pos});
    end

    vsm_halfline_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .tick  (half_tick),
        .clear (ev.accept | ev.fill),
        .cnt   (cnt)
    );

    vsm_frame_out u_out (
        .clk         (clk),
        .rst         (rst),
        .ev          (ev),
        .cnt_lsb     (cnt[0]),
        .frame_pulse (frame_pulse),
        .field_odd   (field_odd),
        .fill_flag   (fill_flag)
    );

    // R4: an edge inside the masked region gives no pulse unless a fill is due
    a_r4_masked: assert property (@(posedge clk) disable iff (rst)
        (rise && (cnt < mask_start) && !(half_tick && cnt >= fill_pos)) |=> !frame_pulse);

    // R3: an accepted edge gives a real pulse
    a_r3_accept_pulse: assert property (@(posedge clk) disable iff (rst)
        (rise && cnt >= mask_start) |=> (frame_pulse && !fill_flag));

    // R8: an accepted pulse takes the parity of the count
    a_r8_parity: assert property (@(posedge clk) disable iff (rst)
        (rise && cnt >= mask_start) |=> (field_odd == $past(cnt[0])));

    // R7: the count is zero in the cycle the frame pulse shows
    a_r7_pulse_zero: assert property (@(posedge clk) disable iff (rst)
        frame_pulse |-> (cnt == '0));

endmodule

// File: tb/sim_vsync_field_gen.sv
module sim_vsync_field_gen;
    localparam int CLK_P  = 10;
    localparam int W      = 6;
    localparam int WD_MAX = 100000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic half_tick = 1'b0;
    logic src_sel = 1'b0;
    logic vs_comp = 1'b0;
    logic vs_pin = 1'b0;
    logic [W-1:0] mask_start = '0;
    logic [W-1:0] fill_pos = '1;
    logic frame_pulse, field_odd, fill_flag;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    string tag = "R1";

    // behavioural model state
    int m_cnt = 0;
    int m_prev = 0;
    int m_pulse = 0, m_odd = 0, m_fill = 0;

    vsync_field_gen #(.CNT_W(W)) u0 (
        .clk(clk), .rst(rst), .half_tick(half_tick), .src_sel(src_sel),
        .vs_comp(vs_comp), .vs_pin(vs_pin), .mask_start(mask_start),
        .fill_pos(fill_pos), .frame_pulse(frame_pulse),
        .field_odd(field_odd), .fill_flag(fill_flag)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic check(string req, string what, int got, int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s %s: got %0d expected %0d at cycle %0d", req, what, got, exp, cycles);
        end
    endtask

    // reference model, advanced on each rising edge
    always @(posedge clk) begin
        int sel, edge_seen, acc, fil;
        cycles++;
        sel = src_sel ? int'(vs_pin) : int'(vs_comp);
        if (rst) begin
            m_cnt = 0; m_prev = 0; m_pulse = 0; m_odd = 0; m_fill = 0;
        end else begin
            edge_seen = (sel == 1 && m_prev == 0) ? 1 : 0;
            acc = (edge_seen == 1 && m_cnt >= int'(mask_start)) ? 1 : 0;
            fil = (acc == 0 && half_tick && m_cnt >= int'(fill_pos)) ? 1 : 0;
            m_pulse = acc | fil;
            if (acc == 1) begin m_odd = m_cnt % 2; m_fill = 0; end
            else if (fil == 1) begin m_odd = 1 - m_odd; m_fill = 1; end
            if (acc == 1 || fil == 1) m_cnt = 0;
            else if (half_tick) m_cnt = m_cnt + 1;
            m_prev = sel;
        end
    end

    // compare away from the active edge
    always @(negedge clk) begin
        if (cycles > 0) begin
            check(tag, "frame_pulse", int'(frame_pulse), m_pulse);
            check(tag, "field_odd",   int'(field_odd),   m_odd);
            check(tag, "fill_flag",   int'(fill_flag),   m_fill);
        end
        if (cycles > WD_MAX) begin
            errors++;
            $display("FAIL watchdog: run did not finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) half_tick = 1'b1;
            @(negedge clk) half_tick = 1'b0;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        tag = "R1";
        check("R1", "reset pulse", int'(frame_pulse), 0);
        check("R1", "reset field", int'(field_odd), 0);
        check("R1", "reset flag",  int'(fill_flag), 0);
        rst = 1'b0;
        mask_start = 6'd8;
        fill_pos   = 6'd40;

        // R3/R8: accepted edge at count 10 (even)
        tag = "R3";
        ticks(10);
        @(negedge clk) vs_comp = 1'b1;
        @(negedge clk);
        check("R3", "accepted pulse", int'(frame_pulse), 1);
        check("R8", "even field", int'(field_odd), 0);
        check("R3", "real flag", int'(fill_flag), 0);
        @(negedge clk) vs_comp = 1'b0;
        check("R3", "pulse one cycle", int'(frame_pulse), 0);

        // R4: edge at count 3 is masked
        tag = "R4";
        ticks(3);
        @(negedge clk) vs_comp = 1'b1;
        @(negedge clk);
        check("R4", "masked edge", int'(frame_pulse), 0);
        vs_comp = 1'b0;

        // R2: unselected pin ignored, then selected, count 9 (odd)
        tag = "R2";
        ticks(6);
        @(negedge clk) vs_pin = 1'b1;
        @(negedge clk);
        check("R2", "unselected pin", int'(frame_pulse), 0);
        vs_pin = 1'b0;
        @(negedge clk) src_sel = 1'b1;
        @(negedge clk) vs_pin = 1'b1;
        @(negedge clk);
        check("R2", "selected pin", int'(frame_pulse), 1);
        check("R8", "odd field", int'(field_odd), 1);
        vs_pin = 1'b0;

        // R6/R7/R5: substitute at count 40, idle cycles hold the count
        tag = "R6";
        repeat (7) @(negedge clk);
        ticks(40);
        @(negedge clk) half_tick = 1'b1;
        @(negedge clk) half_tick = 1'b0;
        check("R6", "substitute pulse", int'(frame_pulse), 1);
        check("R6", "substitute flag", int'(fill_flag), 1);
        check("R8", "field toggled", int'(field_odd), 0);
        tag = "R9";
        repeat (5) @(negedge clk);
        check("R9", "flag holds", int'(fill_flag), 1);

        // R9: accepted edge and due fill on the same edge
        mask_start = 6'd4;
        fill_pos   = 6'd6;
        ticks(6);
        @(negedge clk) begin half_tick = 1'b1; vs_pin = 1'b1; end
        @(negedge clk) begin half_tick = 1'b0; vs_pin = 1'b0; end
        check("R9", "accept wins pulse", int'(frame_pulse), 1);
        check("R9", "accept wins flag", int'(fill_flag), 0);

        // R6: fill at the top count value
        tag = "R6";
        fill_pos = 6'd63;
        mask_start = 6'd63;
        ticks(70);

        // R5/R7: random traffic against the model
        tag = "R5";
        mask_start = 6'd12;
        fill_pos   = 6'd30;
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            half_tick = ($urandom_range(0, 2) == 0);
            vs_comp   = ($urandom_range(0, 40) == 0);
            vs_pin    = ($urandom_range(0, 25) == 0);
            if ($urandom_range(0, 300) == 0) src_sel = ~src_sel;
        end
        half_tick = 1'b0;
        repeat (3) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule